// File: doc/BRIEF.md
# MII Link Duplex Resolver

This block settles the link state and the duplex and speed class of the primary PHY. It then folds that result into the MAC operating-mode word. A single-cycle check pulse starts a run. The block issues management reads through an MDIO master request port: first the PHY status register (address 1), then the link partner ability register (address 5). The status link flag is latched low in the PHY, so a clear flag is confirmed with a second status read before the block reports that the link is down.

When the link is present, the block ANDs the partner abilities with the local advertisement word. It picks the best common mode in a fixed priority and rewrites two bits of the mode word: full duplex and transmit threshold. A duplex-lock input forces full duplex. If the rewritten word differs from the current one, the block stores it and raises a one-cycle restart request for the MAC. Every run ends with a one-cycle done pulse carrying a result code.

Top module: `link_duplex_resolver`

## Requirements
- R1: After reset, done_o, restart_o and mdio_req_o are low, result_o is 0 and mode_o is all zeros.
- R2: A run reads register 1 and then register 5 at the PHY address sampled with the check pulse. Each request stays asserted with a stable register address until mdio_ack_i, which returns the data in the same cycle.
- R3: A first status value of 0xFFFF ends the run after the two reads with result code 0 (PHY absent). There is no restart and mode_o is unchanged.
- R4: If bit 2 (mask 0x0004) of the first status value is clear, register 1 is read a third time. If that bit is still clear, the run ends with result code 1 (no link), no restart and mode_o unchanged. If the bit is now set, resolution proceeds.
- R5: The negotiated set is the partner ability ANDed with adv_i. The transmit-threshold bit (THR_BIT, default 22) is cleared when any negotiated bit of mask 0x0380 is set, and is set otherwise.
- R6: Duplex uses the highest negotiated mode in the order 0x0100, 0x0200, 0x0080, 0x0040, 0x0020. The full-duplex bit (FD_BIT, default 9) is set only when that mode is 0x0100 or 0x0040, and is cleared when no mode is common.
- R7: With dup_lock_i high at the check pulse, the full-duplex bit is set whatever the negotiated set holds.
- R8: All mode word bits other than FD_BIT and THR_BIT are copied from mode_i as sampled with the check pulse.
- R9: When the resolved word differs from the sampled mode_i, mode_o takes it, result code is 3 (changed) and restart_o is high for exactly the done cycle. Otherwise the code is 2 (unchanged), restart_o stays low and mode_o keeps its value.
- R10: done_o is high for one cycle per accepted check. A check pulse arriving while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_i | input | 1 | Start a link and duplex check |
| phy_addr_i | input | PHY_AW | Address of the primary PHY |
| adv_i | input | DATA_W | Local advertisement word |
| dup_lock_i | input | 1 | Force full duplex |
| mode_i | input | MODE_W | Current MAC operating-mode word |
| mdio_req_o | output | 1 | Management read request, held until acknowledged |
| mdio_phy_o | output | PHY_AW | PHY address of the request |
| mdio_reg_o | output | REG_AW | Register address of the request |
| mdio_ack_i | input | 1 | Read completed, data valid |
| mdio_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 2 | 0 absent, 1 no link, 2 unchanged, 3 changed |
| restart_o | output | 1 | One-cycle MAC restart request |
| mode_o | output | MODE_W | Stored resolved mode word |

## Verification
The PHY model answers each read with a programmable value, so one set of cases covers an all-ones status, a link flag that stays clear, and a link flag that only appears on the re-read. Together these separate the two-read and three-read paths and the early exits. For resolution, ability pairs are chosen in which the partner offers a mode the local side lacks, two modes of different duplex are common at once, only a half-duplex or full-duplex 10 Mb/s mode is common, or nothing is common. These cases show whether the AND and the priority order are honoured. Current mode words with unrelated bits set show that only the two target bits move. A repeat of an already resolved case, and a second check pulse during a run, separate an unchanged result and an ignored pulse from a spurious restart.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  // Result codes reported on result_o
  typedef enum logic [1:0] {
    RES_ABSENT  = 2'd0,
    RES_NOLINK  = 2'd1,
    RES_SAME    = 2'd2,
    RES_CHANGED = 2'd3
  } res_e;

  // How the read sequencer ended a run
  typedef enum logic [1:0] {
    FIN_ABSENT  = 2'd0,
    FIN_NOLINK  = 2'd1,
    FIN_RESOLVE = 2'd2
  } fin_e;

  // Read sequencer states
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_RD_STAT = 3'd1,
    SQ_GAP     = 3'd2,
    SQ_RD_LPA  = 3'd3,
    SQ_DECIDE  = 3'd4,
    SQ_RD_STAT2 = 3'd5,
    SQ_DECIDE2 = 3'd6
  } seq_e;

  // Management register numbers
  localparam int REG_STATUS  = 1;
  localparam int REG_PARTNER = 5;

  // Status register link flag position
  localparam int LINK_BIT = 2;

  // Ability masks
  localparam logic [15:0] FAST_MASK = 16'h0380;
  localparam int NUM_MODES = 5;

endpackage

// File: rtl/ldr_seq.sv
module ldr_seq
  import ldr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [PHY_AW-1:0] phy_o,
  output logic [REG_AW-1:0] reg_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fin_o,
  output fin_e              fin_kind_o,
  output logic [DATA_W-1:0] lpa_o
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [REG_AW-1:0] RA_STAT  = REG_AW'(REG_STATUS);
  localparam logic [REG_AW-1:0] RA_LPA   = REG_AW'(REG_PARTNER);

  seq_e              state;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] stat2_q;
  logic [DATA_W-1:0] lpa_q;
  logic [PHY_AW-1:0] phy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      stat_q     <= '0;
      stat2_q    <= '0;
      lpa_q      <= '0;
      phy_q      <= '0;
      fin_o      <= 1'b0;
      fin_kind_o <= FIN_ABSENT;
    end else begin
      fin_o <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start_i) begin
            phy_q <= phy_addr_i;
            state <= SQ_RD_STAT;
          end
        end
        SQ_RD_STAT: begin
          if (ack_i) begin
            stat_q <= rdata_i;
            state  <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          state <= SQ_RD_LPA;
        end
        SQ_RD_LPA: begin
          if (ack_i) begin
            lpa_q <= rdata_i;
            state <= SQ_DECIDE;
          end
        end
        SQ_DECIDE: begin
          if (stat_q == ALL_ONES) begin
            fin_o      <= 1'b1;
            fin_kind_o <= FIN_ABSENT;
            state      <= SQ_IDLE;
          end else if (!stat_q[LINK_BIT]) begin
            state <= SQ_RD_STAT2;
          end else begin
            fin_o      <= 1'b1;
            fin_kind_o <= FIN_RESOLVE;
            state      <= SQ_IDLE;
          end
        end
        SQ_RD_STAT2: begin
          if (ack_i) begin
            stat2_q <= rdata_i;
            state   <= SQ_DECIDE2;
          end
        end
        SQ_DECIDE2: begin
          fin_o      <= 1'b1;
          fin_kind_o <= stat2_q[LINK_BIT] ? FIN_RESOLVE : FIN_NOLINK;
          state      <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    req_o = (state == SQ_RD_STAT) || (state == SQ_RD_LPA) ||
            (state == SQ_RD_STAT2);
    reg_o = (state == SQ_RD_LPA) ? RA_LPA : RA_STAT;
  end

  assign phy_o  = phy_q;
  assign busy_o = (state != SQ_IDLE);
  assign lpa_o  = lpa_q;

endmodule

// File: rtl/ldr_resolve.sv
module ldr_resolve
  import ldr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MODE_W  = 32,
  parameter int FD_BIT  = 9,
  parameter int THR_BIT = 22
) (
  input  logic [DATA_W-1:0] lpa_i,
  input  logic [DATA_W-1:0] adv_i,
  input  logic              lock_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_o
);

  // Modes from best to worst, with their duplex
  localparam int  PRIO_BIT  [NUM_MODES] = '{8, 9, 7, 6, 5};
  localparam bit  PRIO_FULL [NUM_MODES] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic [DATA_W-1:0] common;
  logic              found;
  logic              full;
  logic              fast;

  assign common = lpa_i & adv_i;
  assign fast   = |(common & DATA_W'(FAST_MASK));

  always_comb begin
    found = 1'b0;
    full  = 1'b0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (!found && common[PRIO_BIT[i]]) begin
        found = 1'b1;
        full  = PRIO_FULL[i];
      end
    end
  end

  always_comb begin
    mode_o          = mode_i;
    mode_o[THR_BIT] = !fast;
    mode_o[FD_BIT]  = full || lock_i;
  end

endmodule

// File: rtl/link_duplex_resolver.sv
module link_duplex_resolver
  import ldr_pkg::*;
#(
  parameter int MODE_W  = 32,
  parameter int FD_BIT  = 9,
  parameter int THR_BIT = 22,
  parameter int DATA_W  = 16,
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              check_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [DATA_W-1:0] adv_i,
  input  logic              dup_lock_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              mdio_req_o,
  output logic [PHY_AW-1:0] mdio_phy_o,
  output logic [REG_AW-1:0] mdio_reg_o,
  input  logic              mdio_ack_i,
  input  logic [DATA_W-1:0] mdio_rdata_i,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              restart_o,
  output logic [MODE_W-1:0] mode_o
);

  logic              busy;
  logic              start;
  logic              fin;
  fin_e              fin_kind;
  logic [DATA_W-1:0] lpa;
  logic [DATA_W-1:0] adv_q;
  logic              lock_q;
  logic [MODE_W-1:0] cur_q;
  logic [MODE_W-1:0] new_mode;

  // Pulses during a run are dropped (R10)
  assign start = check_i && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_q  <= '0;
      lock_q <= 1'b0;
      cur_q  <= '0;
    end else if (start) begin
      adv_q  <= adv_i;
      lock_q <= dup_lock_i;
      cur_q  <= mode_i;
    end
  end

  ldr_seq #(
    .DATA_W(DATA_W),
    .PHY_AW(PHY_AW),
    .REG_AW(REG_AW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .phy_addr_i(phy_addr_i),
    .busy_o    (busy),
    .req_o     (mdio_req_o),
    .phy_o     (mdio_phy_o),
    .reg_o     (mdio_reg_o),
    .ack_i     (mdio_ack_i),
    .rdata_i   (mdio_rdata_i),
    .fin_o     (fin),
    .fin_kind_o(fin_kind),
    .lpa_o     (lpa)
  );

  ldr_resolve #(
    .DATA_W (DATA_W),
    .MODE_W (MODE_W),
    .FD_BIT (FD_BIT),
    .THR_BIT(THR_BIT)
  ) u_res (
    .lpa_i (lpa),
    .adv_i (adv_q),
    .lock_i(lock_q),
    .mode_i(cur_q),
    .mode_o(new_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      result_o  <= RES_ABSENT;
      restart_o <= 1'b0;
      mode_o    <= '0;
    end else begin
      done_o    <= fin;
      restart_o <= 1'b0;
      if (fin) begin
        unique case (fin_kind)
          FIN_ABSENT: result_o <= RES_ABSENT;
          FIN_NOLINK: result_o <= RES_NOLINK;
          default: begin
            if (new_mode != cur_q) begin
              result_o  <= RES_CHANGED;
              restart_o <= 1'b1;
              mode_o    <= new_mode;
            end else begin
              result_o <= RES_SAME;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int MODE_W = 32,
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              mdio_req_o,
  input logic [PHY_AW-1:0] mdio_phy_o,
  input logic [REG_AW-1:0] mdio_reg_o,
  input logic              mdio_ack_i,
  input logic              done_o,
  input logic [1:0]        result_o,
  input logic              restart_o,
  input logic [MODE_W-1:0] mode_o
);

  // R9
  restart_code_chk: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (done_o && result_o == 2'd3));

  // R9
  changed_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o == 2'd3) |-> restart_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mdio_req_o && !mdio_ack_i) |=> (mdio_req_o && $stable(mdio_reg_o) && $stable(mdio_phy_o)));

  // R2
  req_reg_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_req_o |-> (mdio_reg_o == REG_AW'(1) || mdio_reg_o == REG_AW'(5)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_o |-> $stable(mode_o));

  // R3
  absent_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o == 2'd0) |-> !restart_o);

  // R10
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mdio_req_o || !$past(mdio_req_o));

endmodule

bind link_duplex_resolver ldr_checker #(
  .MODE_W(MODE_W),
  .PHY_AW(PHY_AW),
  .REG_AW(REG_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mdio_req_o(mdio_req_o),
  .mdio_phy_o(mdio_phy_o),
  .mdio_reg_o(mdio_reg_o),
  .mdio_ack_i(mdio_ack_i),
  .done_o    (done_o),
  .result_o  (result_o),
  .restart_o (restart_o),
  .mode_o    (mode_o)
);

// File: tb/link_duplex_resolver_test.sv
module link_duplex_resolver_test;

  localparam int MODE_W  = 32;
  localparam int FD_BIT  = 9;
  localparam int THR_BIT = 22;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              check_i = 1'b0;
  logic [4:0]        phy_addr_i = 5'd0;
  logic [15:0]       adv_i = '0;
  logic              dup_lock_i = 1'b0;
  logic [MODE_W-1:0] mode_i = '0;
  logic              mdio_req_o;
  logic [4:0]        mdio_phy_o;
  logic [4:0]        mdio_reg_o;
  logic              mdio_ack_i = 1'b0;
  logic [15:0]       mdio_rdata_i = '0;
  logic              done_o;
  logic [1:0]        result_o;
  logic              restart_o;
  logic [MODE_W-1:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  link_duplex_resolver uut (
    .clk(clk), .rst(rst), .check_i(check_i), .phy_addr_i(phy_addr_i),
    .adv_i(adv_i), .dup_lock_i(dup_lock_i), .mode_i(mode_i),
    .mdio_req_o(mdio_req_o), .mdio_phy_o(mdio_phy_o), .mdio_reg_o(mdio_reg_o),
    .mdio_ack_i(mdio_ack_i), .mdio_rdata_i(mdio_rdata_i),
    .done_o(done_o), .result_o(result_o), .restart_o(restart_o), .mode_o(mode_o)
  );

  // PHY model contents
  logic [15:0] m_stat_a, m_stat_b, m_lpa;
  int          rd_cnt;
  int          stat_reads;
  logic [14:0] rd_seq;
  bit          phy_bad;

  typedef struct packed {
    logic [1:0]        res;
    logic [MODE_W-1:0] mode;
    logic [1:0]        nreads;
  } exp_t;

  exp_t   sb_q[$];
  string  tag_q[$];
  logic [MODE_W-1:0] sb_mode = '0;
  int     extra_done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // PHY responder: two-cycle latency per read
  initial begin
    forever begin
      @(negedge clk);
      if (mdio_req_o && !mdio_ack_i) begin
        logic [4:0] r;
        r = mdio_reg_o;
        if (mdio_phy_o != phy_addr_i) phy_bad = 1'b1;
        repeat (2) @(negedge clk);
        rd_seq = {rd_seq[9:0], r};
        rd_cnt++;
        if (r == 5'd1) begin
          mdio_rdata_i = (stat_reads == 0) ? m_stat_a : m_stat_b;
          stat_reads++;
        end else begin
          mdio_rdata_i = m_lpa;
        end
        mdio_ack_i = 1'b1;
        @(negedge clk);
        mdio_ack_i = 1'b0;
      end
    end
  end

  // Monitor: compares each done against the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        if (sb_q.size() == 0) begin
          extra_done++;
          check(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          exp_t  e;
          string t;
          logic [14:0] eseq;
          e = sb_q.pop_front();
          t = tag_q.pop_front();
          eseq = (e.nreads == 2'd3) ? {5'd1, 5'd5, 5'd1} : {5'd0, 5'd1, 5'd5};
          check(result_o == e.res, t, "result", result_o, e.res);
          check(mode_o == e.mode, t, "mode", mode_o, e.mode);
          check(restart_o == (e.res == 2'd3), "R9", "restart", restart_o, e.res == 2'd3);
          check(rd_cnt == int'(e.nreads) && rd_seq == eseq, "R2", "read order",
                rd_seq, eseq);
          check(!phy_bad, "R2", "phy address", phy_bad, 0);
          @(negedge clk);
          check(!done_o && !restart_o, "R10", "pulse width", {done_o, restart_o}, 0);
        end
      end
    end
  end

  // Reference model from the requirements
  task automatic run_case(input string tag, input logic [15:0] sa, input logic [15:0] lpa,
                          input logic [15:0] sb, input logic [15:0] adv, input bit lock,
                          input logic [MODE_W-1:0] cur, input logic [4:0] phy,
                          input bit second_pulse);
    exp_t e;
    logic [15:0] neg;
    logic full;
    logic [MODE_W-1:0] nm;
    m_stat_a = sa; m_stat_b = sb; m_lpa = lpa;
    rd_cnt = 0; stat_reads = 0; rd_seq = '0; phy_bad = 1'b0;
    e.mode = sb_mode;
    if (sa == 16'hFFFF) begin
      e.res = 2'd0; e.nreads = 2'd2;
    end else if (!sa[2] && !sb[2]) begin
      e.res = 2'd1; e.nreads = 2'd3;
    end else begin
      e.nreads = sa[2] ? 2'd2 : 2'd3;
      neg = lpa & adv;
      if (neg[8])      full = 1'b1;
      else if (neg[9]) full = 1'b0;
      else if (neg[7]) full = 1'b0;
      else if (neg[6]) full = 1'b1;
      else             full = 1'b0;
      nm = cur;
      nm[FD_BIT]  = full | lock;
      nm[THR_BIT] = ((neg & 16'h0380) == 16'h0);
      if (nm != cur) begin
        e.res = 2'd3; e.mode = nm; sb_mode = nm;
      end else begin
        e.res = 2'd2;
      end
    end
    sb_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    phy_addr_i = phy; adv_i = adv; dup_lock_i = lock; mode_i = cur;
    check_i = 1'b1;
    @(negedge clk);
    check_i = 1'b0;
    if (second_pulse) begin
      repeat (3) @(negedge clk);
      check_i = 1'b1;
      mode_i = ~cur;
      @(negedge clk);
      check_i = 1'b0;
    end
    wait (sb_q.size() == 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!done_o && !restart_o && !mdio_req_o, "R1", "idle outputs",
          {done_o, restart_o, mdio_req_o}, 0);
    check(result_o == 2'd0 && mode_o == '0, "R1", "reset values", mode_o, 0);

    // R3 absent
    run_case("R3", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h01E1, 1'b0, 32'h0, 5'd3, 1'b0);
    // R4 link stays down
    run_case("R4", 16'h7809, 16'h41E1, 16'h7809, 16'h01E1, 1'b0, 32'h0, 5'd3, 1'b0);
    // R4 link appears on re-read, R6 100 full wins, R5 fast
    run_case("R4", 16'h7809, 16'h41E1, 16'h782D, 16'h01E1, 1'b0, 32'h0, 5'd7, 1'b0);
    // R9 unchanged repeat
    run_case("R9", 16'h782D, 16'h41E1, 16'h782D, 16'h01E1, 1'b0, 32'h0000_0200, 5'd7, 1'b0);
    // R5 partner offers 100 full, local lacks it
    run_case("R5", 16'h782D, 16'h41E1, 16'h782D, 16'h00E1, 1'b0, 32'h0000_0200, 5'd1, 1'b0);
    // R8 only 10 full, other bits kept
    run_case("R8", 16'h782D, 16'h0041, 16'h782D, 16'h0061, 1'b0, 32'hA5A5_0000, 5'd1, 1'b0);
    // R6 only 10 half
    run_case("R6", 16'h782D, 16'h0021, 16'h782D, 16'h01E1, 1'b0, 32'hA5E5_0200, 5'd2, 1'b0);
    // R6 T4 beats 10 full
    run_case("R6", 16'h782D, 16'h0241, 16'h782D, 16'h03E1, 1'b0, 32'h0040_0200, 5'd2, 1'b0);
    // R7 lock forces full on 10 half
    run_case("R7", 16'h782D, 16'h0021, 16'h782D, 16'h01E1, 1'b1, 32'h0, 5'd4, 1'b0);
    // R6 nothing common
    run_case("R6", 16'h782D, 16'h0401, 16'h782D, 16'h01E1, 1'b0, 32'hFFFF_FFFF, 5'd4, 1'b0);
    // R10 second pulse while busy, unchanged result
    run_case("R10", 16'h782D, 16'h0401, 16'h782D, 16'h01E1, 1'b0, 32'hFFFF_FDFF, 5'd5, 1'b1);
    check(extra_done == 0, "R10", "ignored pulse", extra_done, 0);
    // R3 absent keeps stored mode
    run_case("R3", 16'hFFFF, 16'h0000, 16'hFFFF, 16'h01E1, 1'b0, 32'h0, 5'd6, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule